// File: doc/BRIEF.md
# CPU Clock Stop Gate

This block sits between a free-running CPU clock and the CPU clock output pins. It parks those outputs in response to an asynchronous, active-low stop request. The request is first brought into the CPU clock domain through a flip-flop synchronizer. A small controller then decides when the outputs may stop, and the enable of each clock gate is refreshed only on the falling edge of the source clock. Because of this, a gated output never shows a shortened high phase, and it always comes to rest low while its complement rests high.

After a restart the controller opens a minimum run window of `MIN_RUN` CPU cycles. A stop request seen during that window is held off. When the window closes, the level of the synchronized request decides whether the stop happens. If the request was withdrawn before the window closed, it has no effect. Clocks of other domains do not pass through this block and are not affected by it.

Top module: `cpu_stop_gate`

## Requirements
- R1: While `rst_ni` is low, every true output is low, every complement output is high and `stopped_o` is 0. After reset the outputs run, and a stop request is accepted at once, with no run window pending.
- R2: `stop_req_ni` may change at any time relative to the clock. It is sampled only through a chain of `SYNC_STAGES` (default 2) CPU-clock flip-flops whose idle value is 1.
- R3: Take a running gate whose run window is over, and a request that falls between rising edges. Counting the next rising edge as edge 1, edges 1 to 3 still start full high pulses and every edge from 4 on starts none. `stopped_o` is 0 after edge 2 and 1 after edge 3.
- R4: While stopped, every true output is held at 0 and every complement output at 1.
- R5: Take a stopped gate and a request that rises between rising edges. With the next rising edge as edge 1, edges 1 to 3 produce no pulse and edge 4 starts the first pulse. `stopped_o` is 1 after edge 2 and 0 after edge 3.
- R6: The gate enable changes only on the falling edge of the source clock, so the first pulse after a restart is high for the whole high phase.
- R7: After a restart, at least `MIN_RUN` (default 100) consecutive high pulses are delivered before the outputs stop again. If a request is already pending when the window starts, exactly `MIN_RUN` pulses are delivered.
- R8: A request that is asserted and then withdrawn while the run window is still open causes no missing pulse.
- R9: While running, each complement output is low during the high phase of its true output. The complement is the inverse of the true output at all times.
- R10: Suppose the run window is over and a request is held low for exactly one clock period. Then edges 1 to 3 pulse, edge 4 is skipped and edge 5 pulses again; `stopped_o` is 1 only between edges 3 and 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_cpu_i | input | 1 | Free-running CPU source clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop_req_ni | input | 1 | Asynchronous active-low stop request |
| clk_t_o | output | NUM_OUT | Gated true CPU clocks |
| clk_c_o | output | NUM_OUT | Gated complement CPU clocks |
| stopped_o | output | 1 | High while the controller holds the outputs parked |

## Verification
The bench counts pulses edge by edge around each transition. A synchronizer that is one stage too short or too long, or a registered stage that is missing, shifts the last or first pulse by one edge and is reported. A gate that updates its enable on the rising edge would clip the first pulse after a restart, which shows up as a low sample late in the high phase. A counter that loads an off-by-one value delivers 99 or 101 pulses instead of 100 when a stop is already pending. A controller that latches a request inside the window, instead of looking at its level when the window closes, drops pulses after a withdrawn request. A one-period request must remove exactly one pulse, which catches a controller that leaves the stopped state too late.

// File: rtl/cpu_stop_pkg.sv
package cpu_stop_pkg;

  typedef enum logic [0:0] {
    ST_RUN  = 1'b0,
    ST_STOP = 1'b1
  } gate_state_e;

endpackage

// File: rtl/cpu_stop_rst_sync.sv
// Reset synchronizer: asserts asynchronously, releases on a rising clock edge.
module cpu_stop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/cpu_stop_bit_sync.sv
// Multi-flop synchronizer for a single asynchronous level.
module cpu_stop_bit_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] flop_q;
  logic [STAGES-1:0] flop_d;

  always_comb begin
    flop_d = {flop_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flop_q <= {STAGES{RESET_VAL}};
    end else begin
      flop_q <= flop_d;
    end
  end

  assign sync_o = flop_q[STAGES-1];

endmodule

// File: rtl/cpu_stop_ctrl.sv
// Run/stop controller with a minimum run window after every restart.
module cpu_stop_ctrl
  import cpu_stop_pkg::*;
#(
  parameter int MIN_RUN = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_sync_ni,
  output logic run_en_o,
  output logic stopped_o
);

  localparam int          CW   = $clog2(MIN_RUN);
  localparam logic [CW-1:0] LOAD = CW'(MIN_RUN - 1);

  gate_state_e   state_q, state_d;
  logic [CW-1:0] win_q, win_d;
  logic          win_en;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    win_d   = win_q;
    win_en  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (win_q != '0) begin
          win_d  = win_q - 1'b1;
          win_en = 1'b1;
        end else if (!stop_sync_ni) begin
          state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (stop_sync_ni) begin
          state_d = ST_RUN;
          win_d   = LOAD;
          win_en  = 1'b1;
        end
      end
      default: begin
        state_d = ST_RUN;
      end
    endcase
  end

  // State register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
    end else begin
      state_q <= state_d;
    end
  end

  // Run-window counter with explicit enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
    end else if (win_en) begin
      win_q <= win_d;
    end
  end

  assign run_en_o  = (state_q == ST_RUN);
  assign stopped_o = (state_q == ST_STOP);

endmodule

// File: rtl/cpu_stop_gate_cell.sv
// One gated output pair. The enable is refreshed on the falling edge only.
module cpu_stop_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_t_o,
  output logic clk_c_o
);

  logic en_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_i;
    end
  end

  assign clk_t_o = clk_i & en_q;
  assign clk_c_o = ~clk_t_o;

endmodule

// File: rtl/cpu_stop_gate.sv
module cpu_stop_gate #(
  parameter int NUM_OUT     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  parameter int MIN_RUN     = 100
) (
  input  logic               clk_cpu_i,
  input  logic               rst_ni,
  input  logic               stop_req_ni,
  output logic [NUM_OUT-1:0] clk_t_o,
  output logic [NUM_OUT-1:0] clk_c_o,
  output logic               stopped_o
);

  logic rst_sync_n;
  logic stop_sync_n;
  logic run_en;

  cpu_stop_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk_i       (clk_cpu_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  cpu_stop_bit_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_req_sync (
    .clk_i   (clk_cpu_i),
    .rst_ni  (rst_sync_n),
    .async_i (stop_req_ni),
    .sync_o  (stop_sync_n)
  );

  cpu_stop_ctrl #(
    .MIN_RUN (MIN_RUN)
  ) u_ctrl (
    .clk_i        (clk_cpu_i),
    .rst_ni       (rst_sync_n),
    .stop_sync_ni (stop_sync_n),
    .run_en_o     (run_en),
    .stopped_o    (stopped_o)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    cpu_stop_gate_cell u_cell (
      .clk_i   (clk_cpu_i),
      .rst_ni  (rst_sync_n),
      .en_i    (run_en),
      .clk_t_o (clk_t_o[g]),
      .clk_c_o (clk_c_o[g])
    );
  end

endmodule

// File: rtl/cpu_stop_gate_chk.sv
module cpu_stop_gate_chk #(
  parameter int NUM_OUT     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RUN     = 100
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               stop_req_ni,
  input logic [NUM_OUT-1:0] clk_t_o,
  input logic [NUM_OUT-1:0] clk_c_o,
  input logic               stopped_o
);

  localparam int RW = $clog2(MIN_RUN + 1);

  logic          live_q;
  logic          seen_stop_q;
  logic [RW-1:0] run_len_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_stop_q <= 1'b0;
      run_len_q   <= '0;
    end else begin
      if (stopped_o) seen_stop_q <= 1'b1;
      if (stopped_o) run_len_q <= '0;
      else if (run_len_q != RW'(MIN_RUN)) run_len_q <= run_len_q + 1'b1;
    end
  end

  AST_PARK_LOW: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (stopped_o && $past(stopped_o)) |-> (clk_t_o == '0 && clk_c_o == '1)); // R4

  AST_RUN_PULSE: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (live_q && !stopped_o && !$past(stopped_o)) |-> (clk_t_o == '1 && clk_c_o == '0)); // R9

  AST_MIN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(stopped_o) && seen_stop_q) |-> (run_len_q == RW'(MIN_RUN))); // R7

  AST_STOP_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stopped_o) |-> !$past(stop_req_ni, SYNC_STAGES + 1)); // R2

  AST_RUN_NEEDS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stopped_o) |-> $past(stop_req_ni, SYNC_STAGES + 1)); // R5

endmodule

bind cpu_stop_gate cpu_stop_gate_chk #(
  .NUM_OUT     (NUM_OUT),
  .SYNC_STAGES (SYNC_STAGES),
  .MIN_RUN     (MIN_RUN)
) u_chk (
  .clk_i       (clk_cpu_i),
  .rst_ni      (rst_sync_n),
  .stop_req_ni (stop_req_ni),
  .clk_t_o     (clk_t_o),
  .clk_c_o     (clk_c_o),
  .stopped_o   (stopped_o)
);

// File: tb/sim_cpu_stop_gate.sv
`timescale 1ns/1ps
module sim_cpu_stop_gate;

  localparam int CLK_P   = 10;
  localparam int NUM_OUT = 2;
  localparam int MIN_RUN = 100;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               stop_n;
  logic [NUM_OUT-1:0] clk_t;
  logic [NUM_OUT-1:0] clk_c;
  logic               stopped;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cpu_stop_gate u0 (
    .clk_cpu_i   (clk),
    .rst_ni      (rst_n),
    .stop_req_ni (stop_n),
    .clk_t_o     (clk_t),
    .clk_c_o     (clk_c),
    .stopped_o   (stopped)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Sample 2 ns into the high phase that follows the next rising edge.
  task automatic next_edge();
    @(posedge clk);
    #2;
  endtask

  function automatic bit all_hi(input logic [NUM_OUT-1:0] v);
    return v == '1;
  endfunction

  task automatic check_outputs(input bit exp_run, input string req);
    if (exp_run) begin
      chk(all_hi(clk_t), req, int'(clk_t), (1 << NUM_OUT) - 1);
      chk(clk_c == '0, "R9", int'(clk_c), 0);
    end else begin
      chk(clk_t == '0, req, int'(clk_t), 0);
      chk(all_hi(clk_c), "R4", int'(clk_c), (1 << NUM_OUT) - 1);
    end
  endtask

  task automatic t_reset();
    rst_n  = 1'b0;
    stop_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      next_edge();
      check_outputs(1'b0, "R1");
      chk(stopped == 1'b0, "R1", int'(stopped), 0);
    end
    #1 rst_n = 1'b1;
    repeat (6) next_edge();
    check_outputs(1'b1, "R1");
  endtask

  // R2/R3: request falls between edges, three more pulses, then parked
  task automatic t_stop_latency();
    #1 stop_n = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      next_edge();
      check_outputs(k <= 3, "R2/R3");
      if (k == 2) chk(stopped == 1'b0, "R3", int'(stopped), 0);
      if (k == 3) chk(stopped == 1'b1, "R3", int'(stopped), 1);
    end
  endtask

  // R5/R6 restart, then R7 pending request inside the window
  task automatic t_restart_pending();
    int pulses;
    bit ended;
    #1 stop_n = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      next_edge();
      check_outputs(1'b0, "R5");
      if (k == 2) chk(stopped == 1'b1, "R5", int'(stopped), 1);
      if (k == 3) chk(stopped == 1'b0, "R5", int'(stopped), 0);
    end
    next_edge();
    check_outputs(1'b1, "R5");
    #1 chk(all_hi(clk_t), "R6", int'(clk_t), (1 << NUM_OUT) - 1);
    #1 chk(all_hi(clk_t), "R6", int'(clk_t), (1 << NUM_OUT) - 1);
    stop_n = 1'b0;
    pulses = 1;
    ended  = 1'b0;
    for (int k = 0; k < MIN_RUN + 10; k++) begin
      next_edge();
      if (!ended && all_hi(clk_t)) pulses++;
      else ended = 1'b1;
    end
    chk(pulses == MIN_RUN, "R7", pulses, MIN_RUN);
    check_outputs(1'b0, "R7");
  endtask

  // R8: request withdrawn while the window is open has no effect
  task automatic t_withdraw();
    int lows;
    #1 stop_n = 1'b1;
    repeat (14) next_edge();
    #1 stop_n = 1'b0;
    repeat (5) next_edge();
    #1 stop_n = 1'b1;
    lows = 0;
    for (int k = 0; k < MIN_RUN + 20; k++) begin
      next_edge();
      if (!all_hi(clk_t)) lows++;
    end
    chk(lows == 0, "R8", lows, 0);
    chk(stopped == 1'b0, "R8", int'(stopped), 0);
  endtask

  // R10: a one-period request removes exactly one pulse
  task automatic t_one_period();
    #1 stop_n = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      next_edge();
      if (k == 1) #1 stop_n = 1'b1;
      check_outputs(k != 4, "R10");
      if (k == 3) chk(stopped == 1'b1, "R10", int'(stopped), 1);
      if (k == 4) chk(stopped == 1'b0, "R10", int'(stopped), 0);
    end
  endtask

  initial begin
    t_reset();
    t_stop_latency();
    t_restart_pending();
    t_withdraw();
    t_one_period();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule